// File: doc/BRIEF.md
# SMBus Host Block-Transfer Data Buffer

This block carries the data phase of SMBus block reads and block writes on the host side. Software reaches it through a byte-wide register port. A transaction controller, which is not part of this block, does the bit-level bus signalling. It trades payload bytes with this block over a simple byte-stream interface: it pops the bytes to transmit, pushes the bytes it receives, and pushes the byte count that a slave returns.

There are two modes, and a bit in the auxiliary mode register chooses between them.

- **Buffered mode.** A 32-entry store is filled or drained through one data port. A software index steps forward on every port access. Any read of the control register sends that index back to zero. The bus side streams bytes with no per-byte handshake.
- **Byte-at-a-time mode.** The store is replaced by a single holding byte. After every byte the bus moves, a byte-done flag in the status register is set. The bus interface stays stalled until software services the port and writes one to that flag.

A control command value selects the last byte of a block read, so the controller knows it must not acknowledge that byte. A kill request aborts a transfer that is waiting.

Top module: `smbBlkTop`

## Requirements
- R1: After reset the status, control, auxiliary and count registers read 0x00, `busReady` is 1, and `lastNack`, `pecEn`, `bufMode` and `countErr` are 0.
- R2: Auxiliary register (offset 13) bit 1 enables buffered mode and bit 0 drives `pecEn`. Both read back. Clearing bit 1 returns the block to byte-at-a-time mode.
- R3: In buffered mode, bytes written to the data port (offset 7) land in consecutive slots. Pulses on `txPop` present them on `txData` in the same order. `busReady` stays 1 and status bit 7 stays 0 throughout.
- R4: Any read of the control register (offset 2) sets the software index back to slot 0. The next port write therefore overwrites slot 0.
- R5: In buffered mode, bytes pushed with `rxPush` are stored in order, and data-port reads return them in that order.
- R6: Once the software index reaches the received count (register offset 5), port reads return 0x00. The index never passes slot 31, so a 32-byte read followed by extra reads returns 0x00 for the extras.
- R7: `rxCountPush` loads `rxData` into the count register. `countErr` becomes 1 when that value is 0 or greater than 32, and 0 when it is 1 to 32.
- R8: In byte-at-a-time mode, each `txPop` or `rxPush` sets byte-done (status bit 7) and drops `busReady`. Writing 1 to status bit 7 clears the flag and raises `busReady`. Writing 0 to that bit has no effect.
- R9: In byte-at-a-time mode, a byte pushed with `rxPush` is read back from the data port.
- R10: `lastNack` is 1 while the control register holds the last-byte read command 0x34. It is 0 when the control register holds the ordinary block command 0x14.
- R11: A control write with bit 1 set (kill) does four things: it clears byte-done, clears `countErr`, and resets both the software index and the bus pointer. The kill bit itself reads back as 0.
- R12: Software may write the count register (offset 5). The value reads back and appears on `blkCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 4 | Register offset for software access |
| regWr | input | 1 | Software register write strobe |
| regRd | input | 1 | Software register read strobe |
| regWdata | input | 8 | Software write data |
| regRdata | output | 8 | Software read data, combinational on regSel |
| busStart | input | 1 | Controller starts the data phase; rewinds the bus pointer |
| txPop | input | 1 | Controller takes the byte on txData |
| txData | output | 8 | Next byte to transmit |
| rxPush | input | 1 | Controller delivers a received payload byte |
| rxCountPush | input | 1 | Controller delivers the received block count |
| rxData | input | 8 | Received byte or count |
| busReady | output | 1 | Controller may move the next byte |
| lastNack | output | 1 | Current read byte must be ended with a NACK |
| pecEn | output | 1 | Hardware PEC enable from the auxiliary register |
| bufMode | output | 1 | Buffered mode active |
| countErr | output | 1 | Received count is out of range |
| blkCount | output | 8 | Current byte count |

## Verification
A wrong software index shows up on the first data-port access after a control read or a kill: a byte appears at the wrong place in the `txData` stream, or a port read returns the wrong byte. A stuck or lost byte-done flag is visible on `busReady` one cycle after the byte moves. If the end-of-data handling is wrong, a non-zero byte appears on the first port read past the count. A count-check fault shows on `countErr` the cycle after the count arrives.

// File: rtl/smbBlkPkg.sv
package smbBlkPkg;
  localparam logic [3:0] SEL_STATUS = 4'd0;
  localparam logic [3:0] SEL_CTRL   = 4'd2;
  localparam logic [3:0] SEL_COUNT  = 4'd5;
  localparam logic [3:0] SEL_PORT   = 4'd7;
  localparam logic [3:0] SEL_AUX    = 4'd13;

  // strobes from control to datapath
  typedef struct packed {
    logic portWr;
    logic portRd;
    logic swIdxClr;
    logic busPtrClr;
    logic bufMode;
  } blkStrobeT;
endpackage

// File: rtl/smbBlkCtrl.sv
module smbBlkCtrl
  import smbBlkPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regSel,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWdata,
  input  logic [DW-1:0] portRdata,
  output logic [DW-1:0] regRdata,
  input  logic          busStart,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic          rxCountPush,
  input  logic [DW-1:0] rxData,
  output blkStrobeT     stb,
  output logic          busReady,
  output logic          lastNack,
  output logic          pecEn,
  output logic          bufMode,
  output logic          countErr,
  output logic [DW-1:0] blkCount
);
  localparam logic [DW-1:0] MAXCNT  = DW'(DEPTH);
  localparam logic [DW-1:0] KILLMSK = DW'(2);

  logic [DW-1:0] ctrlReg;
  logic [DW-1:0] countReg;
  logic [1:0]    auxReg;
  logic          byteDone;
  logic          cntBad;

  wire ctrlWr   = regWr && (regSel == SEL_CTRL);
  wire killReq  = ctrlWr && regWdata[1];
  wire stsWr    = regWr && (regSel == SEL_STATUS);
  wire byteMove = !auxReg[1] && (txPop || rxPush);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      countReg <= '0;
      auxReg   <= '0;
      byteDone <= 1'b0;
      cntBad   <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= regWdata & ~KILLMSK;
      if (rxCountPush) countReg <= rxData;
      else if (regWr && (regSel == SEL_COUNT)) countReg <= regWdata;
      if (regWr && (regSel == SEL_AUX)) auxReg <= regWdata[1:0];
      if (killReq) byteDone <= 1'b0;
      else if (byteMove) byteDone <= 1'b1;
      else if (stsWr && regWdata[7]) byteDone <= 1'b0;
      if (killReq) cntBad <= 1'b0;
      else if (rxCountPush) cntBad <= (rxData == '0) || (rxData > MAXCNT);
      else if (busStart) cntBad <= 1'b0;
    end
  end

  always_comb begin
    stb.portWr    = regWr && (regSel == SEL_PORT);
    stb.portRd    = regRd && (regSel == SEL_PORT);
    stb.swIdxClr  = (regRd && (regSel == SEL_CTRL)) || killReq;
    stb.busPtrClr = busStart || killReq;
    stb.bufMode   = auxReg[1];
  end

  always_comb begin
    unique case (regSel)
      SEL_STATUS: regRdata = {byteDone, {(DW-1){1'b0}}};
      SEL_CTRL:   regRdata = ctrlReg;
      SEL_COUNT:  regRdata = countReg;
      SEL_PORT:   regRdata = portRdata;
      SEL_AUX:    regRdata = {{(DW-2){1'b0}}, auxReg};
      default:    regRdata = '0;
    endcase
  end

  assign busReady = auxReg[1] || !byteDone;
  assign lastNack = (ctrlReg[5:2] == 4'b1101);
  assign pecEn    = auxReg[0];
  assign bufMode  = auxReg[1];
  assign countErr = cntBad;
  assign blkCount = countReg;
endmodule

// File: rtl/smbBlkData.sv
module smbBlkData
  import smbBlkPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  blkStrobeT     stb,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] swWdata,
  input  logic [DW-1:0] rxData,
  input  logic          txPop,
  input  logic          rxPush,
  output logic [DW-1:0] portRdata,
  output logic [DW-1:0] txData
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] swIdx;
  logic [IW-1:0] busPtr;
  logic          overrun;
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (stb.bufMode && rxPush) mem[busPtr] <= rxData;
    else if (stb.bufMode && stb.portWr) mem[swIdx] <= swWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swIdx   <= '0;
      overrun <= 1'b0;
      busPtr  <= '0;
      hold    <= '0;
    end else begin
      if (stb.swIdxClr) begin
        swIdx   <= '0;
        overrun <= 1'b0;
      end else if (stb.bufMode && (stb.portWr || stb.portRd)) begin
        if (swIdx != LAST) swIdx <= swIdx + 1'b1;
        else if (stb.portRd) overrun <= 1'b1;
      end
      if (stb.busPtrClr) busPtr <= '0;
      else if (stb.bufMode && (txPop || rxPush) && (busPtr != LAST))
        busPtr <= busPtr + 1'b1;
      if (!stb.bufMode) begin
        if (rxPush) hold <= rxData;
        else if (stb.portWr) hold <= swWdata;
      end
    end
  end

  wire [DW-1:0] swIdxWide = DW'(swIdx);
  wire          pastEnd   = overrun || (swIdxWide >= count);

  assign portRdata = stb.bufMode ? (pastEnd ? '0 : mem[swIdx]) : hold;
  assign txData    = stb.bufMode ? mem[busPtr] : hold;
endmodule

// File: rtl/smbBlkTop.sv
module smbBlkTop
  import smbBlkPkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regSel,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          busStart,
  input  logic          txPop,
  output logic [DW-1:0] txData,
  input  logic          rxPush,
  input  logic          rxCountPush,
  input  logic [DW-1:0] rxData,
  output logic          busReady,
  output logic          lastNack,
  output logic          pecEn,
  output logic          bufMode,
  output logic          countErr,
  output logic [DW-1:0] blkCount
);
  blkStrobeT     stb;
  logic [DW-1:0] portRdata;

  smbBlkCtrl #(.DEPTH(DEPTH), .DW(DW)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .portRdata(portRdata), .regRdata(regRdata),
    .busStart(busStart), .txPop(txPop), .rxPush(rxPush),
    .rxCountPush(rxCountPush), .rxData(rxData), .stb(stb),
    .busReady(busReady), .lastNack(lastNack), .pecEn(pecEn),
    .bufMode(bufMode), .countErr(countErr), .blkCount(blkCount)
  );

  smbBlkData #(.DEPTH(DEPTH), .DW(DW)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .count(blkCount),
    .swWdata(regWdata), .rxData(rxData), .txPop(txPop), .rxPush(rxPush),
    .portRdata(portRdata), .txData(txData)
  );
endmodule

// File: rtl/smbBlkChk.sv
module smbBlkChk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] regSel,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic       txPop,
  input logic       rxCountPush,
  input logic [7:0] rxData,
  input logic       busReady,
  input logic       bufMode,
  input logic       pecEn,
  input logic       countErr
);
  p_stream_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && txPop && !regWr) |=> busReady);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!bufMode && txPop && !regWr) |=> !busReady);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && !regWr) |=> !busReady);

  p_kill_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 4'd2 && regWdata[1]) |=> (busReady && !countErr));

  p_aux_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 4'd13) |=>
      (pecEn == $past(regWdata[0]) && bufMode == $past(regWdata[1])));

  p_cnt_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxCountPush && rxData == 8'd0 && !regWr) |=> countErr);
endmodule

bind smbBlkTop smbBlkChk i_chk (.*);

// File: tb/test_smbBlkTop.sv
`timescale 1ns/1ps
module test_smbBlkTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regSel = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       busStart = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxCountPush = 1'b0;
  logic [7:0] rxData = '0;
  logic [7:0] txData, blkCount;
  logic       busReady, lastNack, pecEn, bufMode, countErr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smbBlkTop i_smbBlkTop (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); regSel = s; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk); regSel = s; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); txPop = 1'b1; #1 d = txData;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic rxByte(input logic [7:0] d);
    @(negedge clk); rxData = d; rxPush = 1'b1;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic rxCnt(input logic [7:0] d);
    @(negedge clk); rxData = d; rxCountPush = 1'b1;
    @(negedge clk); rxCountPush = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); busStart = 1'b1;
    @(negedge clk); busStart = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    rd(4'd0, v);  chk("R1 status", v, 8'h00);
    rd(4'd2, v);  chk("R1 ctrl", v, 8'h00);
    rd(4'd13, v); chk("R1 aux", v, 8'h00);
    rd(4'd5, v);  chk("R1 count", v, 8'h00);
    chk("R1 flags", {3'b0, busReady, lastNack, pecEn, bufMode, countErr}, 8'h10);
  endtask

  task automatic tBufWrite();
    logic [7:0] v;
    wr(4'd13, 8'h02);
    chk("R2 bufMode on", {7'b0, bufMode}, 8'h01);
    wr(4'd5, 8'd3);
    rd(4'd2, v);
    wr(4'd7, 8'hA1); wr(4'd7, 8'hA2); wr(4'd7, 8'hA3);
    start();
    pop(v); chk("R3 tx byte0", v, 8'hA1);
    pop(v); chk("R3 tx byte1", v, 8'hA2);
    pop(v); chk("R3 tx byte2", v, 8'hA3);
    chk("R3 no stall", {7'b0, busReady}, 8'h01);
    rd(4'd0, v); chk("R3 no byte-done", v, 8'h00);
    // R4: control read rewinds index
    rd(4'd2, v);
    wr(4'd7, 8'hB0);
    start();
    pop(v); chk("R4 slot0 overwritten", v, 8'hB0);
    pop(v); chk("R4 slot1 kept", v, 8'hA2);
  endtask

  task automatic tBufRead();
    logic [7:0] v;
    int bad;
    start();
    rxCnt(8'd4);
    chk("R7 count 4 ok", {7'b0, countErr}, 8'h00);
    chk("R7 count loaded", blkCount, 8'd4);
    rxByte(8'hC0); rxByte(8'hC1); rxByte(8'hC2); rxByte(8'hC3);
    chk("R5 no stall on rx", {7'b0, busReady}, 8'h01);
    rd(4'd2, v);
    for (int i = 0; i < 4; i++) begin
      rd(4'd7, v); chk("R5 rx byte", v, 8'hC0 + 8'(i));
    end
    rd(4'd7, v); chk("R6 past count", v, 8'h00);
    // full 32-byte read
    start();
    rxCnt(8'd32);
    for (int i = 0; i < 32; i++) rxByte(8'(i * 7 + 3));
    rd(4'd2, v);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      rd(4'd7, v);
      if (v !== 8'(i * 7 + 3)) bad++;
    end
    chk("R5 32-byte read mismatches", 8'(bad), 8'd0);
    rd(4'd7, v); chk("R6 read 33", v, 8'h00);
    rd(4'd7, v); chk("R6 read 34", v, 8'h00);
    rd(4'd2, v);
    rd(4'd7, v); chk("R6 rewind after saturation", v, 8'd3);
  endtask

  task automatic tCount();
    logic [7:0] v;
    rxCnt(8'd0);  chk("R7 count 0 bad", {7'b0, countErr}, 8'h01);
    rxCnt(8'd33); chk("R7 count 33 bad", {7'b0, countErr}, 8'h01);
    rxCnt(8'd1);  chk("R7 count 1 ok", {7'b0, countErr}, 8'h00);
    rxCnt(8'd32); chk("R7 count 32 ok", {7'b0, countErr}, 8'h00);
    wr(4'd5, 8'h11);
    rd(4'd5, v); chk("R12 count readback", v, 8'h11);
    chk("R12 blkCount", blkCount, 8'h11);
  endtask

  task automatic tByteMode();
    logic [7:0] v;
    wr(4'd13, 8'h01);
    chk("R2 pec on buf off", {6'b0, pecEn, bufMode}, 8'h02);
    rd(4'd13, v); chk("R2 aux readback", v, 8'h01);
    wr(4'd7, 8'hD5);
    pop(v); chk("R8 tx hold byte", v, 8'hD5);
    chk("R8 stalled", {7'b0, busReady}, 8'h00);
    rd(4'd0, v); chk("R8 byte-done set", v, 8'h80);
    wr(4'd0, 8'h00);
    chk("R8 write 0 ignored", {7'b0, busReady}, 8'h00);
    wr(4'd7, 8'hD6);
    wr(4'd0, 8'h80);
    chk("R8 released", {7'b0, busReady}, 8'h01);
    rd(4'd0, v); chk("R8 byte-done clear", v, 8'h00);
    pop(v); chk("R8 next byte", v, 8'hD6);
    wr(4'd0, 8'h80);
    rxByte(8'hE7);
    chk("R9 rx stall", {7'b0, busReady}, 8'h00);
    rd(4'd7, v); chk("R9 rx byte", v, 8'hE7);
    wr(4'd0, 8'h80);
    chk("R9 released", {7'b0, busReady}, 8'h01);
  endtask

  task automatic tLast();
    logic [7:0] v;
    wr(4'd2, 8'h34);
    chk("R10 last nack", {7'b0, lastNack}, 8'h01);
    rd(4'd2, v); chk("R10 ctrl readback", v, 8'h34);
    wr(4'd2, 8'h14);
    chk("R10 normal ack", {7'b0, lastNack}, 8'h00);
  endtask

  task automatic tKill();
    logic [7:0] v;
    pop(v);
    chk("R11 stall before kill", {7'b0, busReady}, 8'h00);
    wr(4'd2, 8'h16);
    chk("R11 kill releases", {7'b0, busReady}, 8'h01);
    rd(4'd0, v); chk("R11 byte-done cleared", v, 8'h00);
    rd(4'd2, v); chk("R11 kill bit reads 0", v, 8'h14);
    rxCnt(8'd0);
    wr(4'd2, 8'h02);
    chk("R11 countErr cleared", {7'b0, countErr}, 8'h00);
    wr(4'd13, 8'h02);
    rd(4'd2, v);
    wr(4'd7, 8'hF1); wr(4'd7, 8'hF2);
    start();
    pop(v); chk("R11 pre-kill pop", v, 8'hF1);
    wr(4'd2, 8'h16);
    wr(4'd7, 8'hF3);
    pop(v); chk("R11 indices reset", v, 8'hF3);
    wr(4'd13, 8'h00);
    chk("R2 back to byte mode", {6'b0, pecEn, bufMode}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBufWrite();
    tBufRead();
    tCount();
    tByteMode();
    tLast();
    tKill();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule